// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block sits between the active-low hardware reset pin of a flash memory controller model and its internal program/erase engine. It watches the reset pin, measures how long it stays low and discards pulses that are too short to count as a reset. When a pulse qualifies, it raises an internal reset request and keeps it raised while the pin stays low. After the pin is released, it keeps the request raised for a recovery time. The recovery time depends on what the device was doing when the pin first went low.

If the engine was idle (read or standby), recovery is short and the ready/busy line is left alone. If the engine was programming, erasing or holding an erase in suspension, recovery is long. In that case the ready/busy line is pulled low from the moment the reset qualifies until recovery ends, so its release marks the end of the reset. A reset that interrupts a program or erase also raises a one-cycle flag saying that the data being worked on can no longer be trusted.

Outside reset, the block gates incoming commands. While the engine reports busy, only a suspend request is let through. The ready/busy line is modelled as an open-drain output: the block only ever asserts a pull-down enable. All time limits are derived from nanosecond parameters and the clock period.

Top module: `flash_rst_sequencer`

## Requirements
- R1: A reset counts only after the pin has been sampled low on PULSE_CYC consecutive rising edges, where PULSE_CYC = ceil(500 ns / clock period). int_reset_o rises in the cycle that follows that edge. A low pulse seen on fewer edges leaves int_reset_o low and data_corrupt_o low.
- R2: Once raised, int_reset_o stays high for as long as the pin stays low, and then through the whole recovery period.
- R3: The mode code sampled on the first low edge of the pulse selects the recovery. Read (mode_i = 0) and standby (mode_i = 1) give a short recovery: int_reset_o falls SHORT_CYC = ceil(50 ns / period) edges after the first edge that samples the pin high. rb_pull_low_o stays low throughout.
- R4: Program (2), erase (3) and erase-suspend (4) give a long recovery of LONG_CYC = ceil(10 us / period) edges after the first edge that samples the pin high. rb_pull_low_o stays high from the cycle int_reset_o rises until it falls.
- R5: At the end of a long recovery, rb_pull_low_o is released in the same cycle that int_reset_o falls, provided busy_i is low.
- R6: While int_reset_o is low, rb_pull_low_o equals busy_i. In particular the line is released in erase-suspend and in standby, where the engine reports not busy.
- R7: cmd_accept_o is high only when cmd_valid_i is high, int_reset_o is low, the pin is high, and either busy_i is low or cmd_suspend_i is high.
- R8: data_corrupt_o is high for exactly one cycle, the first cycle of int_reset_o. It does this only when the sampled mode is program (2) or erase (3), and never for read, standby or erase-suspend.
- R9: A new qualified low pulse during recovery returns the block to holding. Recovery then restarts in full from the next release, still long if the first reset was long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin_n | input | 1 | Hardware reset pin, active low, already synchronised |
| mode_i | input | 3 | Engine mode: 0 read, 1 standby, 2 program, 3 erase, 4 erase-suspend |
| busy_i | input | 1 | Engine busy with a program or erase |
| cmd_valid_i | input | 1 | A command is being presented |
| cmd_suspend_i | input | 1 | The presented command is an erase-suspend |
| int_reset_o | output | 1 | Internal reset request to the engine |
| cmd_accept_o | output | 1 | Presented command is accepted |
| rb_pull_low_o | output | 1 | Open-drain pull-down enable for the ready/busy line |
| data_corrupt_o | output | 1 | One-cycle flag: a program or erase was aborted |

## Verification
The hardest case to reach is a second reset that arrives while a long recovery is still counting. The pin has to go low again after the first release, stay low for a full qualifying width, and then be released again, all before the 2500-cycle recovery ends. The bench reaches it by issuing a program-mode reset, waiting a fixed stretch into recovery, then applying a second full-width pulse. It then measures the restarted recovery length from the second release. Boundary pulse widths of PULSE_CYC-1 and PULSE_CYC edges are both applied in an abort-capable mode, so that a pulse that only just fails can be told apart from one that only just counts.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_STANDBY = 3'd1,
    MD_PROGRAM = 3'd2,
    MD_ERASE   = 3'd3,
    MD_SUSPEND = 3'd4
  } op_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_HOLD    = 2'd1,
    SQ_RECOVER = 2'd2
  } seq_state_e;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int dur_ns, input int period_ps);
    int c;
    c = (dur_ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Modes whose reset needs the long recovery.
  function automatic logic mode_is_long(input logic [2:0] m);
    return (m == MD_PROGRAM) || (m == MD_ERASE) || (m == MD_SUSPEND);
  endfunction

  // Modes in which a reset destroys work in progress.
  function automatic logic mode_aborts(input logic [2:0] m);
    return (m == MD_PROGRAM) || (m == MD_ERASE);
  endfunction

endpackage

// File: rtl/frs_pulse_meter.sv
`timescale 1ns/1ps
module frs_pulse_meter #(
  parameter int LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic first_low_o,
  output logic qualify_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SAT   = CW'(LIMIT);
  localparam logic [CW-1:0] LAST  = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // Consecutive low samples, saturating once the width has been met.
  always_comb begin
    if (pin_n) begin
      run_d = '0;
    end else if (run_q == SAT) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  assign first_low_o = !pin_n && (run_q == '0);
  assign qualify_o   = !pin_n && (run_q == LAST);

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SAT);                                                   // R1
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_n |=> (run_q == '0));                                        // R1

endmodule

// File: rtl/frs_recovery_timer.sv
`timescale 1ns/1ps
module frs_recovery_timer #(
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic long_i,
  output logic done_o
);

  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_T = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_T  = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] target;
  logic          cnt_en;

  assign target = long_i ? LONG_T : SHORT_T;
  assign done_o = (cnt_q == target);
  assign cnt_en = start_i || (run_i && !done_o);

  always_comb begin
    if (start_i) begin
      cnt_d = CW'(1);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_T);                                                // R4
  AST_TIMER_FROZEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(cnt_q));                        // R3

endmodule

// File: rtl/frs_rb_gate.sv
`timescale 1ns/1ps
module frs_rb_gate
  import frs_pkg::*;
(
  input  seq_state_e st_i,
  input  logic       long_i,
  input  logic       busy_i,
  input  logic       pin_n,
  input  logic       cmd_valid_i,
  input  logic       cmd_suspend_i,
  output logic       rb_pull_low_o,
  output logic       cmd_accept_o
);

  logic idle;

  assign idle = (st_i == SQ_IDLE);

  // Outside reset the engine owns the line; during reset only a long
  // recovery pulls it down.
  always_comb begin
    if (idle) begin
      rb_pull_low_o = busy_i;
    end else begin
      rb_pull_low_o = long_i;
    end
  end

  always_comb begin
    cmd_accept_o = 1'b0;
    if (cmd_valid_i && idle && pin_n) begin
      cmd_accept_o = !busy_i || cmd_suspend_i;
    end
  end

endmodule

// File: rtl/flash_rst_sequencer.sv
`timescale 1ns/1ps
module flash_rst_sequencer
  import frs_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MIN_LOW_NS    = 500,
  parameter int SHORT_REC_NS  = 50,
  parameter int LONG_REC_NS   = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin_n,
  input  logic [2:0] mode_i,
  input  logic       busy_i,
  input  logic       cmd_valid_i,
  input  logic       cmd_suspend_i,
  output logic       int_reset_o,
  output logic       cmd_accept_o,
  output logic       rb_pull_low_o,
  output logic       data_corrupt_o
);

  localparam int PULSE_CYC = ns_to_cycles(MIN_LOW_NS, CLK_PERIOD_PS);
  localparam int SHORT_CYC = ns_to_cycles(SHORT_REC_NS, CLK_PERIOD_PS);
  localparam int LONG_CYC  = ns_to_cycles(LONG_REC_NS, CLK_PERIOD_PS);

  seq_state_e st_q;
  seq_state_e st_d;
  logic [2:0] cap_q;
  logic [2:0] sel_mode;
  logic       long_q;
  logic       corrupt_q;
  logic       corrupt_d;
  logic       first_low;
  logic       qualify;
  logic       rec_done;
  logic       rec_start;
  logic       enter_hold;

  frs_pulse_meter #(.LIMIT(PULSE_CYC)) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n       (rst_pin_n),
    .first_low_o (first_low),
    .qualify_o   (qualify)
  );

  assign rec_start = (st_q == SQ_HOLD) && rst_pin_n;

  frs_recovery_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rec_start),
    .run_i   (st_q == SQ_RECOVER),
    .long_i  (long_q),
    .done_o  (rec_done)
  );

  frs_rb_gate u_gate (
    .st_i          (st_q),
    .long_i        (long_q),
    .busy_i        (busy_i),
    .pin_n         (rst_pin_n),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_suspend_i (cmd_suspend_i),
    .rb_pull_low_o (rb_pull_low_o),
    .cmd_accept_o  (cmd_accept_o)
  );

  // The mode in force when the pulse began; on a width-of-one pulse the
  // capture and the qualification fall on the same edge.
  assign sel_mode   = first_low ? mode_i : cap_q;
  assign enter_hold = (st_q == SQ_IDLE) && qualify;
  assign corrupt_d  = enter_hold && mode_aborts(sel_mode);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:    if (qualify) st_d = SQ_HOLD;
      SQ_HOLD:    if (rst_pin_n) st_d = SQ_RECOVER;
      SQ_RECOVER: begin
        if (qualify) begin
          st_d = SQ_HOLD;
        end else if (rec_done) begin
          st_d = SQ_IDLE;
        end
      end
      default:    st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      corrupt_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      corrupt_q <= corrupt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= MD_READ;
    end else if (first_low) begin
      cap_q <= mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q <= 1'b0;
    end else if (enter_hold) begin
      long_q <= mode_is_long(sel_mode);
    end
  end

  assign int_reset_o    = (st_q != SQ_IDLE);
  assign data_corrupt_o = corrupt_q;

  AST_HOLD_NEEDS_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_HOLD) && ($past(st_q) == SQ_IDLE)) |-> $past(!rst_pin_n)); // R1
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int_reset_o && !rst_pin_n) |=> int_reset_o);                    // R2
  AST_SHORT_LEAVES_RB: assert property (@(posedge clk) disable iff (!rst_n)
    (int_reset_o && !long_q) |-> !rb_pull_low_o);                    // R3
  AST_LONG_PULLS_RB: assert property (@(posedge clk) disable iff (!rst_n)
    (int_reset_o && long_q) |-> rb_pull_low_o);                      // R4
  AST_NO_ACCEPT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    int_reset_o |-> !cmd_accept_o);                                  // R7
  AST_CORRUPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_corrupt_o |=> !data_corrupt_o);                             // R8
  AST_CORRUPT_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    data_corrupt_o |-> (int_reset_o && !long_q == 1'b0));            // R8

endmodule

// File: tb/flash_rst_sequencer_test.sv
`timescale 1ns/1ps
module flash_rst_sequencer_test;

  localparam int P = 125;   // 500 ns at 4 ns
  localparam int S = 13;    // 50 ns at 4 ns, rounded up
  localparam int L = 2500;  // 10 us at 4 ns

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_pin_n;
  logic [2:0] mode_i;
  logic       busy_i;
  logic       cmd_valid_i;
  logic       cmd_suspend_i;
  logic       int_reset_o;
  logic       cmd_accept_o;
  logic       rb_pull_low_o;
  logic       data_corrupt_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit started = 1'b0;
  bit manual_cmd = 1'b0;
  bit corrupt_seen;

  // reference model state
  int m_phase;   // 0 idle, 1 holding, 2 recovering
  int m_run;
  int m_cap;
  bit m_long;
  int m_left;
  bit m_corrupt;
  bit m_first, m_qual, m_enter;
  int m_sel;

  always #2 clk = ~clk;

  flash_rst_sequencer uut (
    .clk (clk), .rst_n (rst_n), .rst_pin_n (rst_pin_n), .mode_i (mode_i),
    .busy_i (busy_i), .cmd_valid_i (cmd_valid_i), .cmd_suspend_i (cmd_suspend_i),
    .int_reset_o (int_reset_o), .cmd_accept_o (cmd_accept_o),
    .rb_pull_low_o (rb_pull_low_o), .data_corrupt_o (data_corrupt_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
    if (!rst_n) begin
      m_phase = 0; m_run = 0; m_cap = 0; m_long = 0; m_left = 0; m_corrupt = 0;
    end else begin
      m_first = !rst_pin_n && (m_run == 0);
      m_qual  = !rst_pin_n && (m_run == P - 1);
      m_sel   = m_first ? int'(mode_i) : m_cap;
      m_enter = (m_phase == 0) && m_qual;
      m_corrupt = m_enter && (m_sel == 2 || m_sel == 3);
      if (m_first) m_cap = int'(mode_i);
      if (m_enter) m_long = (m_sel >= 2 && m_sel <= 4);
      case (m_phase)
        0: if (m_qual) m_phase = 1;
        1: if (rst_pin_n) begin m_phase = 2; m_left = (m_long ? L : S) - 1; end
        default: begin
          if (m_qual) m_phase = 1;
          else if (m_left == 0) m_phase = 0;
          else m_left--;
        end
      endcase
      if (rst_pin_n) m_run = 0;
      else if (m_run < P) m_run++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      bit e_int, e_rb, e_acc;
      e_int = (m_phase != 0);
      e_rb  = (m_phase == 0) ? busy_i : m_long;
      e_acc = cmd_valid_i && (m_phase == 0) && rst_pin_n && (!busy_i || cmd_suspend_i);
      chk(int_reset_o == e_int, "R2 int_reset", int_reset_o, e_int);
      chk(rb_pull_low_o == e_rb, "R6 rb_pull_low", rb_pull_low_o, e_rb);
      chk(cmd_accept_o == e_acc, "R7 cmd_accept", cmd_accept_o, e_acc);
      chk(data_corrupt_o == m_corrupt, "R8 data_corrupt", data_corrupt_o, m_corrupt);
      if (data_corrupt_o) corrupt_seen = 1'b1;
    end
  end

  // background command pattern
  initial begin
    cmd_valid_i = 1'b0; cmd_suspend_i = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (!manual_cmd) begin
        cmd_valid_i   = (cyc % 3) != 0;
        cmd_suspend_i = (cyc % 5) == 1;
      end
    end
  end

  // One reset pulse; returns negedges with int_reset high after release,
  // plus ready/busy just before and at the end of the reset.
  task automatic pulse(input int mode, input bit busy, input int lo,
                       output int hi_cnt, output bit rb_last, output bit rb_end);
    @(posedge clk); #1;
    mode_i = 3'(mode); busy_i = busy; rst_pin_n = 1'b0; corrupt_seen = 1'b0;
    repeat (lo) @(posedge clk);
    #1 rst_pin_n = 1'b1; busy_i = 1'b0;
    hi_cnt = 0; rb_last = 1'b0;
    @(negedge clk);
    while (int_reset_o && hi_cnt < 6000) begin
      hi_cnt++; rb_last = rb_pull_low_o;
      @(negedge clk);
    end
    rb_end = rb_pull_low_o;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    int n; bit rl, re;
    rst_n = 1'b0; rst_pin_n = 1'b1; mode_i = 3'd0; busy_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(int_reset_o == 1'b0, "R2 reset state int_reset", int_reset_o, 0);
    chk(data_corrupt_o == 1'b0, "R8 reset state corrupt", data_corrupt_o, 0);
    chk(rb_pull_low_o == 1'b0, "R6 reset state rb", rb_pull_low_o, 0);
    @(posedge clk); #1 rst_n = 1'b1; started = 1'b1;
    repeat (3) @(posedge clk);

    // R6: line follows busy outside reset
    #1 mode_i = 3'd2; busy_i = 1'b1;
    @(negedge clk) chk(rb_pull_low_o == 1'b1, "R6 busy program", rb_pull_low_o, 1);
    @(posedge clk); #1 mode_i = 3'd4; busy_i = 1'b0;
    @(negedge clk) chk(rb_pull_low_o == 1'b0, "R6 erase-suspend released", rb_pull_low_o, 0);
    @(posedge clk); #1 mode_i = 3'd1;
    @(negedge clk) chk(rb_pull_low_o == 1'b0, "R6 standby released", rb_pull_low_o, 0);

    // R7: command gating
    @(posedge clk); #1 manual_cmd = 1'b1; busy_i = 1'b1; cmd_valid_i = 1'b1; cmd_suspend_i = 1'b0;
    @(negedge clk) chk(cmd_accept_o == 1'b0, "R7 busy rejects program", cmd_accept_o, 0);
    @(posedge clk); #1 cmd_suspend_i = 1'b1;
    @(negedge clk) chk(cmd_accept_o == 1'b1, "R7 busy takes suspend", cmd_accept_o, 1);
    @(posedge clk); #1 busy_i = 1'b0; cmd_suspend_i = 1'b0;
    @(negedge clk) chk(cmd_accept_o == 1'b1, "R7 ready takes command", cmd_accept_o, 1);
    @(posedge clk); #1 rst_pin_n = 1'b0;
    @(negedge clk) chk(cmd_accept_o == 1'b0, "R7 pin low blocks", cmd_accept_o, 0);
    @(posedge clk); #1 rst_pin_n = 1'b1; manual_cmd = 1'b0;
    repeat (3) @(posedge clk);

    // R1: one edge short in program mode is ignored
    pulse(2, 1'b1, P - 1, n, rl, re);
    chk(n == 0, "R1 short pulse ignored", n, 0);
    chk(corrupt_seen == 1'b0, "R1 short pulse no abort", corrupt_seen, 0);

    // R3: read mode, exact width
    pulse(0, 1'b0, P, n, rl, re);
    chk(n == S + 1, "R3 read recovery", n, S + 1);
    chk(rl == 1'b0, "R3 read keeps rb released", rl, 0);

    // R3: standby, long low time
    pulse(1, 1'b0, P + 40, n, rl, re);
    chk(n == S + 1, "R3 standby recovery", n, S + 1);

    // R4/R5/R8: program mode
    pulse(2, 1'b1, P, n, rl, re);
    chk(n == L + 1, "R4 program recovery", n, L + 1);
    chk(rl == 1'b1 && re == 1'b0, "R5 rb released at end", {rl, re}, 2);
    chk(corrupt_seen == 1'b1, "R8 program abort flagged", corrupt_seen, 1);

    // R8: erase mode aborts
    pulse(3, 1'b1, P + 3, n, rl, re);
    chk(corrupt_seen == 1'b1, "R8 erase abort flagged", corrupt_seen, 1);
    chk(n == L + 1, "R4 erase recovery", n, L + 1);

    // R4/R8: erase-suspend is long but not an abort
    pulse(4, 1'b0, P, n, rl, re);
    chk(n == L + 1, "R4 suspend recovery", n, L + 1);
    chk(corrupt_seen == 1'b0, "R8 suspend no abort", corrupt_seen, 0);

    // R9: second reset during long recovery restarts it
    @(posedge clk); #1 mode_i = 3'd2; busy_i = 1'b1; rst_pin_n = 1'b0;
    repeat (P) @(posedge clk);
    #1 rst_pin_n = 1'b1; busy_i = 1'b0; mode_i = 3'd0;
    repeat (300) @(posedge clk);
    pulse(0, 1'b0, P, n, rl, re);
    chk(n == L + 1, "R9 restarted long recovery", n, L + 1);
    chk(rl == 1'b1, "R9 rb held through restart", rl, 1);

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule